// File: doc/BRIEF.md
# Multiple-Capture HDR Pixel Combiner

This block extends the dynamic range of an image sensor that is read several times, without reset, inside one integration period. The reads of a pixel have exposures of T, 2T, 4T, 8T, 16T and 32T, and arrive as a stream of samples. Each sample is tagged with its capture index (0 to 5) and its pixel address. For every pixel the block keeps, in a small per-pixel state memory, the latest sample that stayed below a programmable saturation threshold, together with the index of that capture.

When capture 5 of a pixel has been taken in, the block scales the kept sample to the 32T exposure by a left shift. It then emits one extended-range word for that pixel and clears the pixel's state for the next frame. Each pixel is processed only from its own samples, so the captures of different pixels may be interleaved freely. A capture that arrives out of its expected order is flagged and discarded.

Top module: `hdr_combiner`

## Requirements
- R1: After reset, `out_valid` and `order_err` are 0, and every pixel expects capture index 0 next, so a full sequence 0..5 starts without error. A reset in the middle of a pixel's sequence discards it.
- R2: A sample strictly below `sat_thresh` at an accepted capture k replaces the pixel's kept sample and index. The emitted value is the last such sample shifted left by (5 - k), in a 13-bit word.
- R3: Once a pixel has a saturated capture in the current frame, its kept sample and index stay unchanged for the rest of that frame, even when later samples are below the threshold.
- R4: If capture 0 of a pixel is saturated, the emitted value is the maximum code 8191.
- R5: `out_valid` rises for exactly one cycle, the cycle after an accepted capture 5 is presented, with `out_addr` equal to that pixel's address. It is never high at any other time.
- R6: A capture whose index differs from the one the pixel expects sets `order_err` for one cycle, the cycle after it is presented. The pixel expects 0 after reset and after its capture 5, and otherwise the previous index plus 1. This includes any index above 5. The capture leaves the pixel's state unchanged and produces no output.
- R7: Pixels are independent: interleaved sequences on different addresses give the same results as sequences presented one after another.
- R8: A sample equal to `sat_thresh` counts as saturated, and the threshold is an input that can be changed between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sat_thresh | input | 8 | Saturation level; samples at or above it are saturated |
| in_valid | input | 1 | A capture sample is presented this cycle |
| in_addr | input | ADDR_W (4) | Pixel address of the sample |
| in_cap | input | 3 | Capture index, 0 (T) to 5 (32T) |
| in_sample | input | 8 | Digitized sample value |
| out_valid | output | 1 | Final pixel value valid |
| out_addr | output | ADDR_W (4) | Pixel address of the final value |
| out_value | output | 13 | Extended-range pixel value on the 32T scale |
| order_err | output | 1 | One-cycle pulse: capture index out of order, capture dropped |

## Verification
A corrupted kept sample or index for a pixel shows only at that pixel's capture 5, one cycle later, as a wrong value or a wrong shift on `out_value`. The vectors therefore use distinct sample patterns, so that each capture position can be the one that is kept. A corrupted expected-index field shows at the next capture of that pixel, as a spurious `order_err` pulse or a missing `out_valid`. The duplicate-capture and reset-in-sequence tests expose this. State leaking between addresses shows at the interleaved sequence's outputs.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
    localparam int SAMP_W   = 8;
    localparam int NUM_CAP  = 6;
    localparam int CAP_W    = $clog2(NUM_CAP);
    localparam int LAST_CAP = NUM_CAP - 1;
    localparam int OUT_W    = SAMP_W + LAST_CAP;

    typedef logic [CAP_W-1:0]  cap_t;
    typedef logic [SAMP_W-1:0] samp_t;
    typedef logic [OUT_W-1:0]  hdr_t;

    localparam cap_t LAST_IDX  = cap_t'(LAST_CAP);
    localparam cap_t FIRST_IDX = '0;
    localparam hdr_t HDR_MAX   = '1;

    // Per-pixel state kept between captures of one frame
    typedef struct packed {
        logic  sat;        // a saturated capture was seen this frame
        logic  first_sat;  // the very first capture was saturated
        cap_t  keep_idx;   // capture index of the kept sample
        samp_t keep;       // last unsaturated sample
        cap_t  next_cap;   // capture index expected next
    } pix_state_t;

    localparam pix_state_t STATE_INIT = '0;

    // Result of examining one incoming capture
    typedef struct packed {
        logic accept;
        logic emit;
        logic err;
    } upd_flags_t;

    // Bring a sample taken at capture idx onto the longest exposure scale
    function automatic hdr_t scale_to_long(input samp_t s, input cap_t idx);
        hdr_t w;
        w = hdr_t'(s);
        return w << (LAST_IDX - idx);
    endfunction
endpackage

// File: rtl/hdr_state_mem.sv
module hdr_state_mem
    import hdr_pkg::*;
#(
    parameter int NPIX   = 16,
    parameter int ADDR_W = $clog2(NPIX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output pix_state_t        rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  pix_state_t        wr_data
);
    pix_state_t mem [NPIX];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPIX; i++) mem[i] <= STATE_INIT;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/hdr_capture_update.sv
module hdr_capture_update
    import hdr_pkg::*;
(
    input  pix_state_t cur,
    input  cap_t       cap,
    input  samp_t      samp,
    input  samp_t      thresh,
    output pix_state_t merged,
    output pix_state_t wb,
    output upd_flags_t flags
);
    logic hit;

    always_comb begin
        hit          = (samp >= thresh);
        merged       = cur;
        flags.accept = (cap == cur.next_cap);
        flags.err    = !flags.accept;
        flags.emit   = flags.accept && (cap == LAST_IDX);

        if (flags.accept) begin
            merged.next_cap = (cap == LAST_IDX) ? FIRST_IDX : cap + cap_t'(1);
            if (!cur.sat) begin
                if (hit) begin
                    merged.sat = 1'b1;
                    if (cap == FIRST_IDX) merged.first_sat = 1'b1;
                end else begin
                    merged.keep     = samp;
                    merged.keep_idx = cap;
                end
            end
        end

        wb = flags.emit ? STATE_INIT : merged;
    end
endmodule

// File: rtl/hdr_scale.sv
module hdr_scale
    import hdr_pkg::*;
(
    input  pix_state_t st,
    output hdr_t       value
);
    always_comb begin
        if (st.first_sat) value = HDR_MAX;
        else              value = scale_to_long(st.keep, st.keep_idx);
    end
endmodule

// File: rtl/hdr_combiner.sv
module hdr_combiner
    import hdr_pkg::*;
#(
    parameter int NPIX   = 16,
    parameter int ADDR_W = $clog2(NPIX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SAMP_W-1:0] sat_thresh,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [CAP_W-1:0]  in_cap,
    input  logic [SAMP_W-1:0] in_sample,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [OUT_W-1:0]  out_value,
    output logic              order_err
);
    pix_state_t cur_st, merged_st, wb_st;
    upd_flags_t flags;
    hdr_t       scaled;

    hdr_state_mem #(.NPIX(NPIX), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (in_addr),
        .rd_data (cur_st),
        .wr_en   (in_valid && flags.accept),
        .wr_addr (in_addr),
        .wr_data (wb_st)
    );

    hdr_capture_update u_upd (
        .cur    (cur_st),
        .cap    (in_cap),
        .samp   (in_sample),
        .thresh (sat_thresh),
        .merged (merged_st),
        .wb     (wb_st),
        .flags  (flags)
    );

    hdr_scale u_scale (
        .st    (merged_st),
        .value (scaled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_value <= '0;
            order_err <= 1'b0;
        end else begin
            out_valid <= in_valid && flags.emit;
            order_err <= in_valid && flags.err;
            if (in_valid && flags.emit) begin
                out_addr  <= in_addr;
                out_value <= scaled;
            end
        end
    end
endmodule

// File: rtl/hdr_combiner_chk.sv
module hdr_combiner_chk
    import hdr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [CAP_W-1:0] in_cap,
    input logic             out_valid,
    input logic             order_err
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !order_err));

    assert_emit_after_last_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid) && ($past(in_cap) == LAST_IDX)));

    assert_err_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
        order_err |-> $past(in_valid));

    assert_err_blocks_emit_R6: assert property (@(posedge clk) disable iff (rst)
        order_err |-> !out_valid);

    assert_bad_index_flagged_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && ($past(in_cap) > LAST_IDX)) |-> order_err);
endmodule

bind hdr_combiner hdr_combiner_chk u_chk (.*);

// File: tb/hdr_combiner_bench.sv
module hdr_combiner_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  sat_thresh = 8'd250;
    logic        in_valid = 1'b0;
    logic [3:0]  in_addr = '0;
    logic [2:0]  in_cap = '0;
    logic [7:0]  in_sample = '0;
    logic        out_valid;
    logic [3:0]  out_addr;
    logic [12:0] out_value;
    logic        order_err;

    int checks = 0;
    int failures = 0;
    logic        got_v, got_e;
    logic [3:0]  got_a;
    logic [12:0] got_val;

    always #2.5 clk = ~clk;

    hdr_combiner u_hdr_combiner (
        .clk(clk), .rst(rst), .sat_thresh(sat_thresh),
        .in_valid(in_valid), .in_addr(in_addr), .in_cap(in_cap), .in_sample(in_sample),
        .out_valid(out_valid), .out_addr(out_addr), .out_value(out_value), .order_err(order_err)
    );

    // Vector table: threshold, six samples {s5..s0}, expected final value
    localparam int NV = 8;
    localparam logic [7:0] V_THR [NV] = '{8'd250, 8'd250, 8'd250, 8'd250,
                                          8'd250, 8'd250, 8'd100, 8'd100};
    localparam logic [47:0] V_SMP [NV] = '{
        {8'd245, 8'd160, 8'd80, 8'd40, 8'd20, 8'd10},   // all below: keep capture 5
        {8'd255, 8'd160, 8'd80, 8'd40, 8'd20, 8'd10},   // last saturates: 160<<1
        {8'd10,  8'd10,  8'd10, 8'd250, 8'd200, 8'd100},// equal at cap2, later ignored: 200<<4
        {8'd1,   8'd1,   8'd1,  8'd1,  8'd1,  8'd255},  // first saturated: max
        {8'd0,   8'd0,   8'd0,  8'd0,  8'd0,  8'd0},
        {8'd96,  8'd48,  8'd24, 8'd12, 8'd6,  8'd3},
        {8'd1,   8'd1,   8'd1,  8'd100, 8'd99, 8'd50},  // threshold 100: 99<<4
        {8'd1,   8'd1,   8'd1,  8'd1,  8'd1,  8'd120}   // threshold 100, first saturated
    };
    localparam logic [12:0] V_EXP [NV] = '{13'd245, 13'd320, 13'd3200, 13'd8191,
                                           13'd0, 13'd96, 13'd1584, 13'd8191};

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic drive(input int a, input int c, input int s);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a[3:0]; in_cap = c[2:0]; in_sample = s[7:0];
        @(posedge clk);
        #1;
        got_v = out_valid; got_e = order_err; got_a = out_addr; got_val = out_value;
        in_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Full six-capture sequence for one pixel, checks the final output
    task automatic run_pixel(input int a, input logic [47:0] smp, input int exp, input string tag);
        bit early = 0;
        bit errs = 0;
        for (int k = 0; k < 6; k++) begin
            drive(a, k, int'(smp[8*k +: 8]));
            if (k < 5 && got_v) early = 1;
            if (got_e) errs = 1;
        end
        chk(!early && !errs, {tag, " R5 no output or error before capture 5"}, int'(early), 0);
        chk(got_v && got_a == a[3:0] && got_val == exp[12:0], tag, int'(got_val), exp);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!out_valid && !order_err, "R1 outputs quiet after reset", int'(out_valid), 0);

        // Table walk: R2, R3, R4, R8
        for (int i = 0; i < NV; i++) begin
            sat_thresh = V_THR[i];
            run_pixel(i, V_SMP[i], int'(V_EXP[i]), $sformatf("R2/R3/R4/R8 vector %0d", i));
        end
        sat_thresh = 8'd250;

        // R6: starting at capture 1 is flagged and ignored
        drive(9, 1, 7);
        chk(got_e && !got_v, "R6 skipped index flagged", int'(got_e), 1);
        run_pixel(9, {6{8'd7}}, 7, "R6 state untouched after skipped index");

        // R6: duplicate capture 0 ignored; R3: later saturated captures keep first
        drive(10, 0, 50);
        drive(10, 0, 60);
        chk(got_e, "R6 duplicate index flagged", int'(got_e), 1);
        for (int k = 1; k < 6; k++) drive(10, k, 255);
        chk(got_v && got_val == 13'd1600, "R6/R3 duplicate dropped, kept 50<<5", int'(got_val), 1600);

        // R6: index above 5
        drive(14, 6, 3);
        chk(got_e && !got_v, "R6 index 6 flagged", int'(got_e), 1);
        idle();

        // R7: interleaved pixels 11 and 12
        for (int k = 0; k < 6; k++) begin
            drive(11, k, k + 1);
            if (k == 5) chk(got_v && got_a == 4'd11 && got_val == 13'd6,
                            "R7 interleaved pixel 11", int'(got_val), 6);
            drive(12, k, (k == 0) ? 200 : 255);
            if (k == 5) chk(got_v && got_a == 4'd12 && got_val == 13'd6400,
                            "R7 interleaved pixel 12", int'(got_val), 6400);
        end

        // R1: reset in mid-sequence restarts the pixel
        drive(13, 0, 9);
        drive(13, 1, 9);
        do_reset();
        drive(13, 0, 1);
        chk(!got_e, "R1 capture 0 accepted after reset", int'(got_e), 0);
        for (int k = 1; k < 6; k++) drive(13, k, (k == 5) ? 2 : 1);
        chk(got_v && got_val == 13'd2, "R1 sequence after reset", int'(got_val), 2);

        // R5: no stray output on an idle cycle after an emission
        idle();
        @(posedge clk); #1;
        chk(!out_valid, "R5 output is a single-cycle pulse", int'(out_valid), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule